// File: doc/BRIEF.md
# Pin Input Sense Interrupt Unit

This block watches a small group of input pins, up to eight, and raises two port interrupts when a pin shows the condition set for it. Each pin first passes through an optional inversion. The result is synchronised into the core clock domain by two flops. Each pin then has its own sense mode: any edge, rising edge, falling edge, or low level. When the sensed condition occurs, a per-pin flag is set. A single flag vector feeds two interrupt outputs, and each output has its own pin mask.

Software sets up the unit through a small register port with single-cycle writes and combinational reads. It clears flags by writing ones to them. A combinational wake-up output also exists. It compares the raw inverted pins against the last synchronised state, so a wake-up request can be seen even when the clock is stopped.

Top module: `pin_sense_irq`

## Requirements
- R1: A pad change reaches the flag after exactly three rising clock edges: two synchroniser stages plus the flag register. The flag is still clear after the second edge.
- R2: Each pin has a 2-bit mode: 00 sets the flag on either edge, 01 on a rising edge only, 10 on a falling edge only, 11 while the sensed value is low. Edges are found by comparing the synchronised value with its value one cycle earlier.
- R3: When a pin's invert bit is 1, sensing, the wake-up term and the sensed-value register all use the complement of the pad.
- R4: Flags are sticky. Writing 1 to a flag bit clears only that bit; bits written with 0 keep their value. A flag never rises unless its sense condition was met.
- R5: If a sense event and a clearing write reach the same flag in the same cycle, the flag ends set.
- R6: In low-level mode, the flag is set in every cycle the sensed value is low, so a clear has no effect while the pin stays low.
- R7: Interrupt output k (k = 0, 1) is the OR over all pins of flag AND mask k. The two outputs are independent, and an all-zero mask keeps its output low.
- R8: wake_o is combinational. It is high when a pin enabled in either mask shows its condition between the raw inverted pad and the synchronised value: differing for mode 00, raw 1 / synced 0 for 01, raw 0 / synced 1 for 10, raw 0 for 11.
- R9: Register map (3-bit address): 0 = modes, with pin i at bits 2i+1:2i; 1 = invert; 2 = mask 0; 3 = mask 1; 4 = flags (write 1 to clear); 5 = synchronised sensed value (read-only). Pin i maps to bit i. Reads are zero-extended, and unused addresses read 0.
- R10: After reset, all registers, flags and outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_PINS | Raw pad inputs |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 2*NUM_PINS | Write data |
| reg_rdata_o | output | 2*NUM_PINS | Combinational read data |
| irq_o | output | 2 | Port interrupts 0 and 1 |
| wake_o | output | 1 | Combinational wake-up request |

## Verification
The bench sweeps every pin with every mode and both inversion settings. It drives a full pulse on each pin and predicts the flag, both interrupts and the wake term. A design with swapped mode codes or misplaced inversion would flag the wrong edge. A design that let a clear win over a same-cycle edge would lose the event in the aligned-clear test. A design that allowed low-level flags to be cleared would read 0 right after the clear while the pin was still low. A design with an extra or missing synchroniser stage would show the flag one edge off in the latency check.

// File: rtl/pin_sense_pkg.sv
package pin_sense_pkg;
  typedef enum logic [1:0] {
    SENSE_BOTH = 2'b00,
    SENSE_RISE = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_LOW  = 2'b11
  } sense_mode_e;

  localparam int REG_ADDR_W = 3;
  localparam logic [REG_ADDR_W-1:0] ADDR_MODE  = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_INV   = 3'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_MASK0 = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_MASK1 = 3'd3;
  localparam logic [REG_ADDR_W-1:0] ADDR_FLAG  = 3'd4;
  localparam logic [REG_ADDR_W-1:0] ADDR_SENSE = 3'd5;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sense_regfile.sv
module sense_regfile
  import pin_sense_pkg::*;
#(
  parameter int NUM_PINS = 8,
  localparam int REG_W   = 2 * NUM_PINS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]      wdata_i,
  output logic [REG_W-1:0]      rdata_o,
  input  logic [NUM_PINS-1:0]   flags_i,
  input  logic [NUM_PINS-1:0]   sensed_i,
  output logic [REG_W-1:0]      mode_o,
  output logic [NUM_PINS-1:0]   inv_o,
  output logic [NUM_PINS-1:0]   mask0_o,
  output logic [NUM_PINS-1:0]   mask1_o,
  output logic [NUM_PINS-1:0]   flag_clr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o  <= '0;
      inv_o   <= '0;
      mask0_o <= '0;
      mask1_o <= '0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_MODE:  mode_o  <= wdata_i;
        ADDR_INV:   inv_o   <= wdata_i[NUM_PINS-1:0];
        ADDR_MASK0: mask0_o <= wdata_i[NUM_PINS-1:0];
        ADDR_MASK1: mask1_o <= wdata_i[NUM_PINS-1:0];
        default: ;
      endcase
    end
  end

  assign flag_clr_o = (we_i && addr_i == ADDR_FLAG) ? wdata_i[NUM_PINS-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_MODE:  rdata_o = mode_o;
      ADDR_INV:   rdata_o[NUM_PINS-1:0] = inv_o;
      ADDR_MASK0: rdata_o[NUM_PINS-1:0] = mask0_o;
      ADDR_MASK1: rdata_o[NUM_PINS-1:0] = mask1_o;
      ADDR_FLAG:  rdata_o[NUM_PINS-1:0] = flags_i;
      ADDR_SENSE: rdata_o[NUM_PINS-1:0] = sensed_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/pin_sense_cell.sv
module pin_sense_cell
  import pin_sense_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  sense_mode_e mode_i,
  input  logic        raw_i,
  input  logic        sync_i,
  input  logic        prev_i,
  input  logic        clr_i,
  input  logic        wake_en_i,
  output logic        hit_o,
  output logic        flag_o,
  output logic        wake_o
);
  logic rise, fall, wake_cond;

  assign rise = sync_i & ~prev_i;
  assign fall = ~sync_i & prev_i;

  always_comb begin
    case (mode_i)
      SENSE_BOTH: begin hit_o = rise | fall; wake_cond = raw_i ^ sync_i;   end
      SENSE_RISE: begin hit_o = rise;        wake_cond = raw_i & ~sync_i;  end
      SENSE_FALL: begin hit_o = fall;        wake_cond = ~raw_i & sync_i;  end
      default:    begin hit_o = ~sync_i;     wake_cond = ~raw_i;           end
    endcase
  end

  assign wake_o = wake_en_i & wake_cond;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (hit_o)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/pin_sense_irq.sv
module pin_sense_irq
  import pin_sense_pkg::*;
#(
  parameter int NUM_PINS = 8,
  localparam int REG_W   = 2 * NUM_PINS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PINS-1:0]   pin_i,
  input  logic                  reg_we_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]      reg_wdata_i,
  output logic [REG_W-1:0]      reg_rdata_o,
  output logic [1:0]            irq_o,
  output logic                  wake_o
);
  logic [REG_W-1:0]    mode_q;
  logic [NUM_PINS-1:0] inv_q, mask0_q, mask1_q, flag_clr;
  logic [NUM_PINS-1:0] pad_sensed, sync_q, prev_q, hit_vec, flags_q, wake_vec;

  sense_regfile #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .flags_i    (flags_q),
    .sensed_i   (sync_q),
    .mode_o     (mode_q),
    .inv_o      (inv_q),
    .mask0_o    (mask0_q),
    .mask1_o    (mask1_q),
    .flag_clr_o (flag_clr)
  );

  assign pad_sensed = pin_i ^ inv_q;

  pin_sync #(.WIDTH(NUM_PINS), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_sensed),
    .q_o    (sync_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_q;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    pin_sense_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mode_i    (sense_mode_e'(mode_q[2*i +: 2])),
      .raw_i     (pad_sensed[i]),
      .sync_i    (sync_q[i]),
      .prev_i    (prev_q[i]),
      .clr_i     (flag_clr[i]),
      .wake_en_i (mask0_q[i] | mask1_q[i]),
      .hit_o     (hit_vec[i]),
      .flag_o    (flags_q[i]),
      .wake_o    (wake_vec[i])
    );
  end

  assign irq_o[0] = |(flags_q & mask0_q);
  assign irq_o[1] = |(flags_q & mask1_q);
  assign wake_o   = |wake_vec;
endmodule

// File: rtl/pin_sense_checker.sv
module pin_sense_checker #(
  parameter int NUM_PINS = 8,
  localparam int REG_W   = 2 * NUM_PINS
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_PINS-1:0] pin_i,
  input logic [1:0]          irq_o,
  input logic                wake_o,
  input logic [REG_W-1:0]    mode_q,
  input logic [NUM_PINS-1:0] inv_q,
  input logic [NUM_PINS-1:0] mask0_q,
  input logic [NUM_PINS-1:0] mask1_q,
  input logic [NUM_PINS-1:0] sync_q,
  input logic [NUM_PINS-1:0] hit_vec,
  input logic [NUM_PINS-1:0] flags_q
);
  logic [NUM_PINS-1:0] low_mode, low_active, raw;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_low
    assign low_mode[i] = (mode_q[2*i +: 2] == 2'b11);
  end
  assign low_active = low_mode & ~sync_q;
  assign raw        = pin_i ^ inv_q;

  AST_HIT_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit_vec) |=> ((flags_q & $past(hit_vec)) == $past(hit_vec))); // R5
  AST_FLAG_NEEDS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flags_q & ~$past(flags_q) & ~$past(hit_vec)) == '0)); // R4
  AST_LOW_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|low_active) |=> ((flags_q & $past(low_active)) == $past(low_active))); // R6
  AST_IRQ0_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask0_q == '0) |-> !irq_o[0]); // R7
  AST_IRQ1_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask1_q == '0) |-> !irq_o[1]); // R7
  AST_WAKE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw == sync_q && (low_mode & ~raw) == '0) |-> !wake_o); // R8
endmodule

bind pin_sense_irq pin_sense_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pin_i   (pin_i),
  .irq_o   (irq_o),
  .wake_o  (wake_o),
  .mode_q  (mode_q),
  .inv_q   (inv_q),
  .mask0_q (mask0_q),
  .mask1_q (mask1_q),
  .sync_q  (sync_q),
  .hit_vec (hit_vec),
  .flags_q (flags_q)
);

// File: tb/tb_pin_sense_irq.sv
module tb_pin_sense_irq;
  localparam int N = 8;
  localparam int W = 2 * N;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin = '0;
  logic         we = 1'b0;
  logic [2:0]   addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic [1:0]   irq;
  logic         wake;
  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pin_sense_irq #(.NUM_PINS(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .wake_o(wake)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  // predicted flag event and wake term for a sensed transition old->new
  function automatic bit ev(input int m, input bit s0, input bit s1);
    case (m)
      0: return s0 != s1;
      1: return s1 & ~s0;
      2: return ~s1 & s0;
      default: return ~s1;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] d;
    repeat (3) @(negedge clk);
    // R10 reset state
    rd(3'd4, d); chk("R10 flags", d, 0);
    rd(3'd0, d); chk("R10 mode", d, 0);
    chk("R10 irq", irq, 0);
    chk("R10 wake", wake, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 register map readback
    wr(3'd0, 16'hA5C3); rd(3'd0, d); chk("R9 mode", d, 16'hA5C3);
    wr(3'd2, 16'hFF5A); rd(3'd2, d); chk("R9 mask0", d, 16'h005A);
    wr(3'd3, 16'h0081); rd(3'd3, d); chk("R9 mask1", d, 16'h0081);
    rd(3'd6, d); chk("R9 unused", d, 0);
    wr(3'd0, 0); wr(3'd2, 0); wr(3'd3, 0);
    settle(); wr(3'd4, 16'hFF);

    // R1 latency and R5 clear aligned with the set edge
    @(negedge clk); pin[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); rd(3'd4, d); chk("R1 flag after 2 edges", d, 0);
    we = 1'b1; addr = 3'd4; wdata = 16'h0001;
    @(negedge clk); we = 1'b0; wdata = '0;
    rd(3'd4, d); chk("R5 set wins over clear", d, 1);
    chk("R7 irq with zero masks", irq, 0);
    rd(3'd5, d); chk("R9 sensed reg", d, 1);
    pin[0] = 1'b0; settle();

    // R4 clear only the written bits
    pin[2:1] = 2'b11; settle();
    wr(3'd4, 16'h00FF); wr(3'd4, 16'h0000);
    pin[2:1] = 2'b00; settle();
    wr(3'd4, 16'h0002); rd(3'd4, d); chk("R4 selective clear", d, 16'h0004);
    // R7 mask1 only
    wr(3'd3, 16'h0004); chk("R7 irq1 only", irq, 2'b10);
    wr(3'd3, 0); wr(3'd4, 16'hFF);

    // sweep: pin x mode x inversion
    for (int p = 0; p < N; p++) begin
      for (int m = 0; m < 4; m++) begin
        for (int inv = 0; inv < 2; inv++) begin
          bit s0, s1, e;
          logic [N-1:0] pm;
          pm = N'(1) << p;
          wr(3'd0, W'(m) << (2 * p));
          wr(3'd1, inv ? W'(pm) : '0);
          wr(3'd2, W'(pm));
          wr(3'd3, W'(~pm));
          settle();
          wr(3'd4, 16'hFF);
          s0 = bit'(inv);
          e = (m == 3) && !s0;
          rd(3'd4, d); chk($sformatf("R6 after clear p%0d m%0d i%0d", p, m, inv), d, W'(e) << p);
          chk("R7 irq1 unselected", irq[1], 0);
          // rising pad
          @(negedge clk); pin[p] = 1'b1; s1 = ~s0; #1;
          chk($sformatf("R8 wake rise p%0d m%0d i%0d", p, m, inv), wake, ev(m, s0, s1));
          settle();
          e = e | ev(m, s0, s1);
          rd(3'd4, d); chk($sformatf("R2 R3 rise p%0d m%0d i%0d", p, m, inv), d, W'(e) << p);
          chk("R7 irq0", irq[0], e);
          wr(3'd4, W'(pm));
          e = (m == 3) && !s1;
          rd(3'd4, d); chk($sformatf("R4 R6 clear p%0d m%0d i%0d", p, m, inv), d, W'(e) << p);
          // falling pad
          @(negedge clk); pin[p] = 1'b0; #1;
          chk($sformatf("R8 wake fall p%0d m%0d i%0d", p, m, inv), wake, ev(m, s1, s0));
          settle();
          e = e | ev(m, s1, s0);
          rd(3'd4, d); chk($sformatf("R2 R3 fall p%0d m%0d i%0d", p, m, inv), d, W'(e) << p);
          wr(3'd1, 0); wr(3'd0, 0); settle(); wr(3'd4, 16'hFF);
        end
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule